// File: doc/BRIEF.md
# Dual-Issue Instruction Steering

This block sits between decode and two unequal execution pipes of a two-wide in-order core. Each cycle it sees two decoded instructions. Slot 0 is the older and slot 1 the younger. Each slot carries a valid flag, a two-bit operation class, a write-enable, a destination register, two source registers and an opaque payload. The block chooses which pipe gets each instruction. It moves the whole instruction bundle (class, control, register fields and payload) to that pipe, and tags the pipe with the slot the instruction came from.

Pipe X takes integer work and branches. Pipe Y takes integer work and memory accesses. When both instructions can go together, the block crosses them over whenever their classes require it. When they cannot, only the older instruction leaves, and `hold_s1` tells the upstream stage that the younger one must be offered again as slot 0. A downstream stall blocks all issue. The parameter `OUT_REG` chooses between a purely combinational path and one register stage on every output.

Top module: `dual_issue_steer`

## Requirements
- R1: Pipe X (`pa_*`) never receives a memory instruction (class 2'b10). A memory instruction in slot 0 always goes to pipe Y.
- R2: Pipe Y (`pb_*`) never receives a branch (class 2'b01). When slot 0 is a branch and slot 1 is a memory instruction, they go in natural order: slot 0 to X and slot 1 to Y.
- R3: When both slots hold integer instructions (class 2'b00) and no hazard exists, slot 0 goes to pipe X with tag 0 and slot 1 goes to pipe Y with tag 1.
- R4: When both issue and either slot 0 is memory or slot 1 is a branch, the pair is crossed over: slot 1 goes to X and slot 0 goes to Y. Class, write-enable, rd, rs1, rs2 and payload all travel together with their instruction.
- R5: When both slots are memory, or both are branches, only slot 0 issues, `issue_cnt` is 1 and `hold_s1` is 1.
- R6: When slot 0 has write-enable set and a nonzero rd that equals slot 1's rs1 or rs2, only slot 0 issues and `hold_s1` is 1. A match on register 0, or a match with write-enable clear, does not split the pair.
- R7: A branch in slot 0 does not block slot 1. An integer or memory instruction in slot 1 issues in the same cycle.
- R8: A slot whose valid flag is 0, or whose class is 2'b11, issues nothing. An instruction that issues alone goes to pipe Y if it is memory and to pipe X otherwise, and its tag shows its slot.
- R9: While `stall` is 1, both pipe valids, `issue_cnt` and `hold_s1` are 0.
- R10: `issue_cnt` equals the number of pipe valids. When both pipes are valid their tags differ. All fields of a pipe that is not valid are 0.
- R11: With `OUT_REG`=1, every output reflects the inputs of the previous clock, and reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stall | input | 1 | Downstream stall, blocks all issue |
| s0_valid | input | 1 | Slot 0 valid |
| s0_cls | input | 2 | Slot 0 class: 00 int, 01 branch, 10 memory, 11 none |
| s0_we | input | 1 | Slot 0 writes rd |
| s0_rd | input | REG_AW | Slot 0 destination |
| s0_rs1 | input | REG_AW | Slot 0 source 1 |
| s0_rs2 | input | REG_AW | Slot 0 source 2 |
| s0_payload | input | PAYLOAD_W | Slot 0 opaque bits |
| s1_valid | input | 1 | Slot 1 valid |
| s1_cls | input | 2 | Slot 1 class |
| s1_we | input | 1 | Slot 1 writes rd |
| s1_rd | input | REG_AW | Slot 1 destination |
| s1_rs1 | input | REG_AW | Slot 1 source 1 |
| s1_rs2 | input | REG_AW | Slot 1 source 2 |
| s1_payload | input | PAYLOAD_W | Slot 1 opaque bits |
| pa_valid | output | 1 | Pipe X receives an instruction |
| pa_slot | output | 1 | Slot that pipe X's instruction came from |
| pa_cls | output | 2 | Pipe X class |
| pa_we | output | 1 | Pipe X write-enable |
| pa_rd | output | REG_AW | Pipe X destination |
| pa_rs1 | output | REG_AW | Pipe X source 1 |
| pa_rs2 | output | REG_AW | Pipe X source 2 |
| pa_payload | output | PAYLOAD_W | Pipe X payload |
| pb_valid | output | 1 | Pipe Y receives an instruction |
| pb_slot | output | 1 | Slot that pipe Y's instruction came from |
| pb_cls | output | 2 | Pipe Y class |
| pb_we | output | 1 | Pipe Y write-enable |
| pb_rd | output | REG_AW | Pipe Y destination |
| pb_rs1 | output | REG_AW | Pipe Y source 1 |
| pb_rs2 | output | REG_AW | Pipe Y source 2 |
| pb_payload | output | PAYLOAD_W | Pipe Y payload |
| issue_cnt | output | 2 | Instructions issued: 0, 1 or 2 |
| hold_s1 | output | 1 | Slot 1 was held back and must be offered again |

## Verification
The bench builds the block with `OUT_REG`=1, `REG_AW`=5 and `PAYLOAD_W`=16. This brings the reset clearing of the output stage and the one-cycle latency within reach, and the reference model accounts for that latency through a queue. In the random phase, register numbers are drawn from 0 to 3. This makes intra-pair read-after-write matches frequent, including matches on register 0, so the hazard split and its exemption are exercised together with every class pairing.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic [1:0] {
    CLS_INT = 2'b00,
    CLS_BR  = 2'b01,
    CLS_MEM = 2'b10,
    CLS_NOP = 2'b11
  } op_cls_e;

  // slot holds something that wants a pipe
  function automatic logic slot_live(input logic v, input logic [1:0] c);
    return v && (c != CLS_NOP);
  endfunction

  // pair cannot go together: same restricted class or data dependence
  function automatic logic pair_clash(input logic [1:0] c0, input logic [1:0] c1,
                                      input logic raw);
    return ((c0 == c1) && (c0 != CLS_INT)) || raw;
  endfunction

  // crossing needed when the older needs Y or the younger needs X
  function automatic logic pair_cross(input logic [1:0] c0, input logic [1:0] c1);
    return (c0 == CLS_MEM) || (c1 == CLS_BR);
  endfunction

  // lone instruction destination: 1 means pipe Y
  function automatic logic lone_to_y(input logic [1:0] c);
    return c == CLS_MEM;
  endfunction

endpackage

// File: rtl/steer_slot_decode.sv
module steer_slot_decode
  import steer_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] cls,
  output logic       active
);
  assign active = slot_live(valid, cls);
endmodule

// File: rtl/steer_hazard.sv
module steer_hazard #(
  parameter int REG_AW = 5
) (
  input  logic              we0,
  input  logic [REG_AW-1:0] rd0,
  input  logic [REG_AW-1:0] rs1_1,
  input  logic [REG_AW-1:0] rs2_1,
  output logic              raw
);
  logic dst_real;
  assign dst_real = we0 && (rd0 != '0);
  assign raw      = dst_real && ((rs1_1 == rd0) || (rs2_1 == rd0));
endmodule

// File: rtl/steer_route.sv
module steer_route
  import steer_pkg::*;
#(
  parameter int IW = 34
) (
  input  logic          stall,
  input  logic          act0,
  input  logic          act1,
  input  logic          conflict,
  input  logic [IW-1:0] in0,
  input  logic [IW-1:0] in1,
  output logic          a_valid,
  output logic          a_slot,
  output logic [IW-1:0] a_bits,
  output logic          b_valid,
  output logic          b_slot,
  output logic [IW-1:0] b_bits,
  output logic [1:0]    cnt,
  output logic          hold
);
  logic [1:0] c0, c1;
  logic       go0, go1;

  assign c0 = in0[IW-1 -: 2];
  assign c1 = in1[IW-1 -: 2];

  always_comb begin
    a_valid = 1'b0; a_slot = 1'b0; a_bits = '0;
    b_valid = 1'b0; b_slot = 1'b0; b_bits = '0;
    go0  = !stall && act0;
    go1  = !stall && act1 && !(act0 && conflict);
    hold = !stall && act0 && act1 && conflict;
    if (go0 && go1) begin
      a_valid = 1'b1; b_valid = 1'b1;
      if (pair_cross(c0, c1)) begin
        a_slot = 1'b1; a_bits = in1;
        b_slot = 1'b0; b_bits = in0;
      end else begin
        a_slot = 1'b0; a_bits = in0;
        b_slot = 1'b1; b_bits = in1;
      end
    end else if (go0) begin
      if (lone_to_y(c0)) begin
        b_valid = 1'b1; b_bits = in0;
      end else begin
        a_valid = 1'b1; a_bits = in0;
      end
    end else if (go1) begin
      if (lone_to_y(c1)) begin
        b_valid = 1'b1; b_slot = 1'b1; b_bits = in1;
      end else begin
        a_valid = 1'b1; a_slot = 1'b1; a_bits = in1;
      end
    end
    cnt = {1'b0, go0} + {1'b0, go1};
  end
endmodule

// File: rtl/steer_out_stage.sv
module steer_out_stage #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_thru
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
  import steer_pkg::*;
#(
  parameter int REG_AW    = 5,
  parameter int PAYLOAD_W = 16,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stall,
  input  logic                 s0_valid,
  input  logic [1:0]           s0_cls,
  input  logic                 s0_we,
  input  logic [REG_AW-1:0]    s0_rd,
  input  logic [REG_AW-1:0]    s0_rs1,
  input  logic [REG_AW-1:0]    s0_rs2,
  input  logic [PAYLOAD_W-1:0] s0_payload,
  input  logic                 s1_valid,
  input  logic [1:0]           s1_cls,
  input  logic                 s1_we,
  input  logic [REG_AW-1:0]    s1_rd,
  input  logic [REG_AW-1:0]    s1_rs1,
  input  logic [REG_AW-1:0]    s1_rs2,
  input  logic [PAYLOAD_W-1:0] s1_payload,
  output logic                 pa_valid,
  output logic                 pa_slot,
  output logic [1:0]           pa_cls,
  output logic                 pa_we,
  output logic [REG_AW-1:0]    pa_rd,
  output logic [REG_AW-1:0]    pa_rs1,
  output logic [REG_AW-1:0]    pa_rs2,
  output logic [PAYLOAD_W-1:0] pa_payload,
  output logic                 pb_valid,
  output logic                 pb_slot,
  output logic [1:0]           pb_cls,
  output logic                 pb_we,
  output logic [REG_AW-1:0]    pb_rd,
  output logic [REG_AW-1:0]    pb_rs1,
  output logic [REG_AW-1:0]    pb_rs2,
  output logic [PAYLOAD_W-1:0] pb_payload,
  output logic [1:0]           issue_cnt,
  output logic                 hold_s1
);
  localparam int IW = 3 + 3 * REG_AW + PAYLOAD_W;
  localparam int OW = 2 * (2 + IW) + 3;

  logic [IW-1:0] ibits [2];
  logic [1:0]    vld;
  logic [1:0]    act;
  logic          raw_w;
  logic          conflict_w;
  logic          nxt_a_valid, nxt_a_slot, nxt_b_valid, nxt_b_slot, nxt_hold;
  logic [IW-1:0] nxt_a_bits, nxt_b_bits;
  logic [1:0]    nxt_cnt;
  logic [OW-1:0] nxt_bus, out_bus;

  assign ibits[0] = {s0_cls, s0_we, s0_rd, s0_rs1, s0_rs2, s0_payload};
  assign ibits[1] = {s1_cls, s1_we, s1_rd, s1_rs1, s1_rs2, s1_payload};
  assign vld      = {s1_valid, s0_valid};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_slot
      steer_slot_decode u_dec (
        .valid  (vld[g]),
        .cls    (ibits[g][IW-1 -: 2]),
        .active (act[g])
      );
    end
  endgenerate

  steer_hazard #(.REG_AW(REG_AW)) u_haz (
    .we0   (s0_we),
    .rd0   (s0_rd),
    .rs1_1 (s1_rs1),
    .rs2_1 (s1_rs2),
    .raw   (raw_w)
  );

  assign conflict_w = pair_clash(s0_cls, s1_cls, raw_w);

  steer_route #(.IW(IW)) u_route (
    .stall    (stall),
    .act0     (act[0]),
    .act1     (act[1]),
    .conflict (conflict_w),
    .in0      (ibits[0]),
    .in1      (ibits[1]),
    .a_valid  (nxt_a_valid),
    .a_slot   (nxt_a_slot),
    .a_bits   (nxt_a_bits),
    .b_valid  (nxt_b_valid),
    .b_slot   (nxt_b_slot),
    .b_bits   (nxt_b_bits),
    .cnt      (nxt_cnt),
    .hold     (nxt_hold)
  );

  assign nxt_bus = {nxt_a_valid, nxt_a_slot, nxt_a_bits,
                    nxt_b_valid, nxt_b_slot, nxt_b_bits, nxt_cnt, nxt_hold};

  steer_out_stage #(.W(OW), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nxt_bus),
    .q     (out_bus)
  );

  assign {pa_valid, pa_slot, pa_cls, pa_we, pa_rd, pa_rs1, pa_rs2, pa_payload,
          pb_valid, pb_slot, pb_cls, pb_we, pb_rd, pb_rs1, pb_rs2, pb_payload,
          issue_cnt, hold_s1} = out_bus;

endmodule

// File: rtl/steer_chk.sv
module steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stall,
  input logic [1:0] act,
  input logic       conflict_w,
  input logic [1:0] nxt_cnt,
  input logic       pa_valid,
  input logic       pa_slot,
  input logic [1:0] pa_cls,
  input logic       pb_valid,
  input logic       pb_slot,
  input logic [1:0] pb_cls,
  input logic [1:0] issue_cnt,
  input logic       hold_s1
);
  // R1
  x_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_valid |-> (pa_cls != 2'b10));
  // R2
  y_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_valid |-> (pb_cls != 2'b01));
  // R9
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (nxt_cnt == 2'd0));
  // R5
  clash_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && act[0] && act[1] && conflict_w) |-> (nxt_cnt == 2'd1));
  // R8
  empty_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'b00) |-> (nxt_cnt == 2'd0));
  // R10
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_cnt == ({1'b0, pa_valid} + {1'b0, pb_valid}));
  // R10
  tags_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && pb_valid) |-> (pa_slot != pb_slot));
  // R5
  hold_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_s1 |-> (issue_cnt == 2'd1));
endmodule

bind dual_issue_steer steer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .act        (act),
  .conflict_w (conflict_w),
  .nxt_cnt    (nxt_cnt),
  .pa_valid   (pa_valid),
  .pa_slot    (pa_slot),
  .pa_cls     (pa_cls),
  .pb_valid   (pb_valid),
  .pb_slot    (pb_slot),
  .pb_cls     (pb_cls),
  .issue_cnt  (issue_cnt),
  .hold_s1    (hold_s1)
);

// File: tb/dual_issue_steer_bench.sv
module dual_issue_steer_bench;
  localparam int RA = 5;
  localparam int PW = 16;
  localparam int BW = 3 + 3 * RA + PW;

  typedef struct {
    bit          v;
    logic [1:0]  c;
    bit          we;
    logic [RA-1:0] rd, r1, r2;
    logic [PW-1:0] p;
  } slot_t;

  typedef struct {
    string       tag;
    bit          av, bv, as, bs, hold;
    int          cnt;
    logic [BW-1:0] ab, bb;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0;
  logic s0_valid = 0, s0_we = 0, s1_valid = 0, s1_we = 0;
  logic [1:0] s0_cls = 2'b11, s1_cls = 2'b11;
  logic [RA-1:0] s0_rd = 0, s0_rs1 = 0, s0_rs2 = 0, s1_rd = 0, s1_rs1 = 0, s1_rs2 = 0;
  logic [PW-1:0] s0_payload = 0, s1_payload = 0;
  logic pa_valid, pa_slot, pa_we, pb_valid, pb_slot, pb_we, hold_s1;
  logic [1:0] pa_cls, pb_cls, issue_cnt;
  logic [RA-1:0] pa_rd, pa_rs1, pa_rs2, pb_rd, pb_rs1, pb_rs2;
  logic [PW-1:0] pa_payload, pb_payload;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  exp_t expq[$];

  always #10 clk = ~clk;

  dual_issue_steer #(.REG_AW(RA), .PAYLOAD_W(PW), .OUT_REG(1'b1)) u_dual_issue_steer (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_we(s0_we), .s0_rd(s0_rd),
    .s0_rs1(s0_rs1), .s0_rs2(s0_rs2), .s0_payload(s0_payload),
    .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_we(s1_we), .s1_rd(s1_rd),
    .s1_rs1(s1_rs1), .s1_rs2(s1_rs2), .s1_payload(s1_payload),
    .pa_valid(pa_valid), .pa_slot(pa_slot), .pa_cls(pa_cls), .pa_we(pa_we),
    .pa_rd(pa_rd), .pa_rs1(pa_rs1), .pa_rs2(pa_rs2), .pa_payload(pa_payload),
    .pb_valid(pb_valid), .pb_slot(pb_slot), .pb_cls(pb_cls), .pb_we(pb_we),
    .pb_rd(pb_rd), .pb_rs1(pb_rs1), .pb_rs2(pb_rs2), .pb_payload(pb_payload),
    .issue_cnt(issue_cnt), .hold_s1(hold_s1)
  );

  function automatic slot_t mk(bit v, logic [1:0] c, bit we, int rd, int r1, int r2, int p);
    slot_t s;
    s.v = v; s.c = c; s.we = we;
    s.rd = RA'(rd); s.r1 = RA'(r1); s.r2 = RA'(r2); s.p = PW'(p);
    return s;
  endfunction

  function automatic logic [BW-1:0] flat(slot_t s);
    return {s.c, s.we, s.rd, s.r1, s.r2, s.p};
  endfunction

  // behavioural reference: pick issuers in age order, then seat fixed classes, then integers
  function automatic exp_t model(string tag, bit st, slot_t s0, slot_t s1);
    exp_t e;
    slot_t sl[2];
    int order[$];
    int seat[2];
    bit live0, live1, dep, clash, x_busy, y_busy;
    sl[0] = s0; sl[1] = s1;
    e.tag = tag; e.av = 0; e.bv = 0; e.as = 0; e.bs = 0; e.ab = '0; e.bb = '0;
    live0 = s0.v && s0.c != 2'b11;
    live1 = s1.v && s1.c != 2'b11;
    dep   = s0.we && s0.rd != 0 && (s1.r1 == s0.rd || s1.r2 == s0.rd);
    clash = dep || (s0.c == 2'b10 && s1.c == 2'b10) || (s0.c == 2'b01 && s1.c == 2'b01);
    if (!st) begin
      if (live0) order.push_back(0);
      if (live1 && !(live0 && clash)) order.push_back(1);
    end
    e.hold = !st && live0 && live1 && clash;
    e.cnt  = order.size();
    seat[0] = -1; seat[1] = -1; x_busy = 0; y_busy = 0;
    foreach (order[k]) begin
      if (sl[order[k]].c == 2'b10) begin seat[order[k]] = 1; y_busy = 1; end
      else if (sl[order[k]].c == 2'b01) begin seat[order[k]] = 0; x_busy = 1; end
    end
    foreach (order[k]) begin
      if (seat[order[k]] < 0) begin
        if (!x_busy) begin seat[order[k]] = 0; x_busy = 1; end
        else begin seat[order[k]] = 1; y_busy = 1; end
      end
    end
    for (int i = 0; i < 2; i++) begin
      if (seat[i] == 0) begin e.av = 1; e.as = i[0]; e.ab = flat(sl[i]); end
      if (seat[i] == 1) begin e.bv = 1; e.bs = i[0]; e.bb = flat(sl[i]); end
    end
    return e;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_one(exp_t e);
    chk(e.tag, "x valid", 64'(pa_valid), 64'(e.av));
    chk(e.tag, "y valid", 64'(pb_valid), 64'(e.bv));
    chk(e.tag, "x tag", 64'(pa_slot), 64'(e.as));
    chk(e.tag, "y tag", 64'(pb_slot), 64'(e.bs));
    chk(e.tag, "x bundle", 64'({pa_cls, pa_we, pa_rd, pa_rs1, pa_rs2, pa_payload}), 64'(e.ab));
    chk(e.tag, "y bundle", 64'({pb_cls, pb_we, pb_rd, pb_rs1, pb_rs2, pb_payload}), 64'(e.bb));
    chk(e.tag, "count", 64'(issue_cnt), 64'(e.cnt));
    chk(e.tag, "hold", 64'(hold_s1), 64'(e.hold));
  endtask

  // compare the previous cycle's expectation, then drive this cycle (R11 latency)
  task automatic step(string tag, bit st, slot_t s0, slot_t s1);
    @(negedge clk);
    if (expq.size() > 0) compare_one(expq.pop_front());
    stall = st;
    s0_valid = s0.v; s0_cls = s0.c; s0_we = s0.we; s0_rd = s0.rd;
    s0_rs1 = s0.r1; s0_rs2 = s0.r2; s0_payload = s0.p;
    s1_valid = s1.v; s1_cls = s1.c; s1_we = s1.we; s1_rd = s1.rd;
    s1_rs1 = s1.r1; s1_rs2 = s1.r2; s1_payload = s1.p;
    expq.push_back(model(tag, st, s0, s1));
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    slot_t n;
    n = mk(0, 2'b11, 0, 0, 0, 0, 0);
    // R11 reset with live inputs present
    s0_valid = 1; s0_cls = 2'b00; s1_valid = 1; s1_cls = 2'b10;
    repeat (3) @(negedge clk);
    chk("R11", "reset valids", 64'({pa_valid, pb_valid}), 64'd0);
    chk("R11", "reset count", 64'({issue_cnt, hold_s1}), 64'd0);
    chk("R11", "reset bundles", 64'({pa_payload, pb_payload, pa_rd, pb_rd}), 64'd0);
    rst_n = 1'b1;

    step("R3",  0, mk(1, 2'b00, 1, 1, 2, 3, 16'h1111), mk(1, 2'b00, 1, 4, 5, 6, 16'h2222));
    step("R1",  0, mk(1, 2'b10, 1, 7, 8, 9, 16'h3333), mk(1, 2'b00, 0, 10, 11, 12, 16'h4444));
    step("R4",  0, mk(1, 2'b00, 1, 3, 4, 5, 16'h5555), mk(1, 2'b01, 0, 6, 7, 8, 16'h6666));
    step("R4",  0, mk(1, 2'b10, 0, 9, 1, 2, 16'h7777), mk(1, 2'b01, 0, 3, 4, 5, 16'h8888));
    step("R2",  0, mk(1, 2'b01, 0, 2, 3, 4, 16'h9999), mk(1, 2'b10, 1, 5, 6, 7, 16'haaaa));
    step("R7",  0, mk(1, 2'b01, 1, 2, 3, 4, 16'hbbbb), mk(1, 2'b00, 1, 8, 9, 10, 16'hcccc));
    step("R5",  0, mk(1, 2'b10, 1, 1, 2, 3, 16'h0101), mk(1, 2'b10, 1, 4, 5, 6, 16'h0202));
    step("R5",  0, mk(1, 2'b01, 0, 1, 2, 3, 16'h0303), mk(1, 2'b01, 0, 4, 5, 6, 16'h0404));
    step("R6",  0, mk(1, 2'b00, 1, 9, 1, 2, 16'h0505), mk(1, 2'b00, 1, 3, 9, 4, 16'h0606));
    step("R6",  0, mk(1, 2'b00, 1, 9, 1, 2, 16'h0707), mk(1, 2'b10, 0, 3, 4, 9, 16'h0808));
    step("R6",  0, mk(1, 2'b00, 1, 0, 1, 2, 16'h0909), mk(1, 2'b00, 1, 3, 0, 0, 16'h0a0a));
    step("R6",  0, mk(1, 2'b00, 0, 9, 1, 2, 16'h0b0b), mk(1, 2'b00, 1, 3, 9, 9, 16'h0c0c));
    step("R8",  0, mk(0, 2'b10, 1, 1, 2, 3, 16'h0d0d), mk(1, 2'b00, 1, 4, 5, 6, 16'h0e0e));
    step("R8",  0, mk(1, 2'b11, 1, 1, 2, 3, 16'h0f0f), mk(1, 2'b10, 1, 4, 5, 6, 16'h1010));
    step("R8",  0, mk(1, 2'b01, 1, 1, 2, 3, 16'h1212), mk(0, 2'b00, 1, 4, 5, 6, 16'h1313));
    step("R8",  0, mk(1, 2'b10, 1, 1, 2, 3, 16'h1414), mk(1, 2'b11, 1, 4, 5, 6, 16'h1515));
    step("R8",  0, n, n);
    step("R9",  1, mk(1, 2'b00, 1, 1, 2, 3, 16'h1616), mk(1, 2'b00, 1, 4, 5, 6, 16'h1717));
    step("R9",  1, mk(1, 2'b10, 1, 1, 2, 3, 16'h1818), mk(1, 2'b10, 1, 4, 5, 6, 16'h1919));

    for (int i = 0; i < 600; i++) begin
      slot_t a, b;
      a = mk(($urandom % 10) != 0, 2'($urandom), 1'($urandom), $urandom % 4,
             $urandom % 4, $urandom % 4, int'($urandom % 65536));
      b = mk(($urandom % 10) != 0, 2'($urandom), 1'($urandom), $urandom % 4,
             $urandom % 4, $urandom % 4, int'($urandom % 65536));
      step("R10", ($urandom % 10) == 0, a, b);
    end
    step("R10", 0, n, n);
    step("R10", 0, n, n);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule